// File: doc/BRIEF.md
# Burst-Mode Processor Clock Gate Controller

This block saves power by letting the processor clock through in bursts instead of continuously. A free-running step counter advances once per pulse of a slow reference tick and repeats every 31 steps. A 5-bit on-time value, compared against that counter, decides how many of the 31 steps the processor clock runs. The block drives a single clock-enable line. An external glitch-free gate cell consumes that line. The enable only ever changes on a system-clock edge.

Software controls the block through one 16-bit configuration word. Three fields matter:

- a power-save enable bit;
- an immediate-stop request bit;
- the on-time field.

When power-save is off, the processor clock simply runs. A wake-capable interrupt drops the enable bit in hardware, so the clock runs freely until software re-arms power-save. The stop request halts the clock ahead of the burst schedule. It takes effect once the bus cycle that follows the next reference tick has completed. It ends at the next start of a burst period, or on a wake interrupt.

Top module: `cpu_burst_gate`

## Requirements
- R1: After reset the configuration word reads 0x001F (enable 0, stop 0, on-time 31), and the clock enable output is 1.
- R2: The read word places the enable at bit 7, the stop status at bit 6 and the on-time at bits 4:0. Bit 5 and bits 15:8 always read 0, whatever value was written.
- R3: While the enable bit is 0 and no stop is in effect, the clock enable is 1 for every on-time value.
- R4: While the enable bit is 1, the step counter runs 0..30 and advances once per tick. The clock enable is 1 exactly while the counter is below the on-time, so on-time W gives W enabled steps out of every 31 (0 gives none, 31 gives all).
- R5: A wake interrupt clears the enable bit, and it wins over a write in the same cycle. The clock enable then returns to 1.
- R6: Writing 1 to bit 6 requests a stop. Bit 6 reads 1 from that write until the stop ends. Writing 0 to bit 6 does not cancel a pending stop.
- R7: A requested stop removes the clock only after the first bus-done strobe that comes after the next tick. A strobe before that tick is ignored. The clock enable falls on the clock edge after the halting strobe is taken.
- R8: A halted clock resumes on the tick that wraps the step counter from 30 to 0. Bit 6 then reads 0.
- R9: A halted clock resumes when a wake interrupt arrives. Bit 6 and the enable bit then read 0.
- R10: The clock enable is a register output. It changes one system clock after the state change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse per rising edge of the slow reference |
| wake_irq | input | 1 | Wake-capable interrupt request |
| bus_done | input | 1 | Pulse marking completion of a processor bus cycle |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read-back |
| cpu_clk_en | output | 1 | Enable for the external processor clock gate |

## Verification
The bench builds the block with its default parameters:

- a 31-step period;
- a 5-bit on-time;
- a 16-bit word with the enable at bit 7 and the stop at bit 6;
- the registered output stage.

These are the only settings under which the on-time of 31 means "always on", and under which the one-cycle output latency of R10 can be measured. A 31-tick observation window covers every counter value whatever the starting phase. This lets duty counts for on-times of 0, 1, 7, 15 and 31 be compared directly. The bench keeps its own tick count modulo 31, so it can predict which tick ends a halt.

// File: rtl/burst_gate_pkg.sv
package burst_gate_pkg;

   // Progress of a software stop request
   typedef enum logic [1:0] {
      PH_RUN   = 2'd0,   // no stop pending
      PH_ARMED = 2'd1,   // waiting for the next slow tick
      PH_DRAIN = 2'd2,   // waiting for the bus cycle to finish
      PH_HALT  = 2'd3    // processor clock removed
   } stop_phase_e;

endpackage

// File: rtl/burst_step_counter.sv
module burst_step_counter #(
   parameter int PERIOD_STEPS = 31,
   parameter int WIDTH_W      = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [WIDTH_W-1:0] on_time,
   output logic               period_wrap,
   output logic               burst_on
);

   localparam int CNT_W = (PERIOD_STEPS > 1) ? $clog2(PERIOD_STEPS) : 1;
   localparam int CMP_W = (CNT_W > WIDTH_W) ? CNT_W : WIDTH_W;
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(PERIOD_STEPS - 1);

   if (PERIOD_STEPS < 2) begin : g_bad_period
      $error("burst_step_counter: PERIOD_STEPS must be at least 2");
   end
   if ((1 << WIDTH_W) - 1 < PERIOD_STEPS) begin : g_bad_width
      $error("burst_step_counter: on-time field cannot express a full period");
   end

   logic [CNT_W-1:0] step_q;

   assign period_wrap = tick && (step_q == LAST_STEP);
   assign burst_on    = CMP_W'(step_q) < CMP_W'(on_time);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (tick) begin
         if (step_q == LAST_STEP) step_q <= '0;
         else                     step_q <= step_q + 1'b1;
      end
   end

   assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      step_q <= LAST_STEP)
      else $error("step counter out of range");

   assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      period_wrap |=> (step_q == '0))
      else $error("counter did not restart after the last step");

   assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(step_q))
      else $error("counter moved without a tick");

endmodule

// File: rtl/burst_ctrl_reg.sv
module burst_ctrl_reg
   import burst_gate_pkg::*;
#(
   parameter int REG_W    = 16,
   parameter int WIDTH_W  = 5,
   parameter int EN_BIT   = 7,
   parameter int STOP_BIT = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   input  logic               wake,
   input  logic               tick,
   input  logic               bus_done,
   input  logic               period_wrap,
   output logic               pc_en,
   output logic [WIDTH_W-1:0] on_time,
   output logic               halted,
   output logic [REG_W-1:0]   rd_data
);

   localparam logic [WIDTH_W-1:0] ON_TIME_RESET = '1;

   if (EN_BIT >= REG_W || STOP_BIT >= REG_W) begin : g_bad_bits
      $error("burst_ctrl_reg: control bit outside the register");
   end
   if (EN_BIT == STOP_BIT) begin : g_same_bits
      $error("burst_ctrl_reg: enable and stop bits collide");
   end
   if (EN_BIT < WIDTH_W || STOP_BIT < WIDTH_W) begin : g_overlap
      $error("burst_ctrl_reg: control bit overlaps the on-time field");
   end

   stop_phase_e phase_q, phase_d;
   logic        pc_en_d;
   logic [WIDTH_W-1:0] on_time_d;

   // Next state of the enable and on-time fields: wake has the final word
   always_comb begin
      pc_en_d   = pc_en;
      on_time_d = on_time;
      if (wr_en) begin
         pc_en_d   = wr_data[EN_BIT];
         on_time_d = wr_data[WIDTH_W-1:0];
      end
      if (wake) pc_en_d = 1'b0;
   end

   // Stop request sequencing
   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_RUN:   if (wr_en && wr_data[STOP_BIT]) phase_d = PH_ARMED;
         PH_ARMED: if (tick)                       phase_d = PH_DRAIN;
         PH_DRAIN: if (bus_done)                   phase_d = PH_HALT;
         PH_HALT:  if (period_wrap)                phase_d = PH_RUN;
         default:                                  phase_d = PH_RUN;
      endcase
      if (wake) phase_d = PH_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_en   <= 1'b0;
         on_time <= ON_TIME_RESET;
         phase_q <= PH_RUN;
      end else begin
         pc_en   <= pc_en_d;
         on_time <= on_time_d;
         phase_q <= phase_d;
      end
   end

   assign halted = (phase_q == PH_HALT);

   always_comb begin
      rd_data                = '0;
      rd_data[EN_BIT]        = pc_en;
      rd_data[STOP_BIT]      = (phase_q != PH_RUN);
      rd_data[WIDTH_W-1:0]   = on_time;
   end

   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   assert_wake_clears_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> !pc_en)
      else $error("wake did not clear the enable bit");

   assert_wake_ends_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake |=> (phase_q == PH_RUN))
      else $error("wake did not end the stop");

   assert_halt_needs_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> $past(bus_done))
      else $error("halt without a completed bus cycle");

   assert_halt_exit_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halted) |-> ($past(period_wrap) || $past(wake)))
      else $error("halt ended without wrap or wake");

   assert_drain_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_ARMED && !tick && !wake) |=> (phase_q == PH_ARMED))
      else $error("stop advanced before the slow tick");

endmodule

// File: rtl/cpu_burst_gate.sv
module cpu_burst_gate #(
   parameter int REG_W        = 16,
   parameter int WIDTH_W      = 5,
   parameter int PERIOD_STEPS = 31,
   parameter int EN_BIT       = 7,
   parameter int STOP_BIT     = 6,
   parameter bit SYNC_OUT     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic             wake_irq,
   input  logic             bus_done,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   output logic             cpu_clk_en
);

   logic               pc_en;
   logic [WIDTH_W-1:0] on_time;
   logic               halted;
   logic               period_wrap;
   logic               burst_on;
   logic               gate_d;

   burst_ctrl_reg #(
      .REG_W    (REG_W),
      .WIDTH_W  (WIDTH_W),
      .EN_BIT   (EN_BIT),
      .STOP_BIT (STOP_BIT)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (cfg_wr),
      .wr_data     (cfg_wdata),
      .wake        (wake_irq),
      .tick        (slow_tick),
      .bus_done    (bus_done),
      .period_wrap (period_wrap),
      .pc_en       (pc_en),
      .on_time     (on_time),
      .halted      (halted),
      .rd_data     (cfg_rdata)
   );

   burst_step_counter #(
      .PERIOD_STEPS (PERIOD_STEPS),
      .WIDTH_W      (WIDTH_W)
   ) u_steps (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (slow_tick),
      .on_time     (on_time),
      .period_wrap (period_wrap),
      .burst_on    (burst_on)
   );

   assign gate_d = !halted && (!pc_en || burst_on);

   if (SYNC_OUT) begin : g_sync_out
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b1;
         else        en_q <= gate_d;
      end
      assign cpu_clk_en = en_q;

      assert_open_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!pc_en && !halted) |=> cpu_clk_en)
         else $error("clock gated while power-save is off");

      assert_closed_when_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
         halted |=> !cpu_clk_en)
         else $error("clock running during a halt");

      assert_full_width_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (pc_en && !halted && on_time == '1) |=> cpu_clk_en)
         else $error("full on-time did not keep the clock running");
   end else begin : g_comb_out
      assign cpu_clk_en = gate_d;
   end

endmodule

// File: tb/cpu_burst_gate_test.sv
module cpu_burst_gate_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        wake_irq = 1'b0;
   logic        bus_done = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        cpu_clk_en;

   int checks = 0;
   int errors = 0;
   int tick_count = 0;
   int cycle_count = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cpu_burst_gate uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .slow_tick  (slow_tick),
      .wake_irq   (wake_irq),
      .bus_done   (bus_done),
      .cfg_wr     (cfg_wr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .cpu_clk_en (cpu_clk_en)
   );

   // on-time value and expected enabled steps per 31-tick window (R4)
   localparam int NVEC = 5;
   localparam int VEC_W  [NVEC] = '{0, 1, 15, 31, 7};
   localparam int VEC_ON [NVEC] = '{0, 1, 15, 31, 7};

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_cfg(input logic [15:0] v, input logic with_wake);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = v; wake_irq = with_wake;
      @(negedge clk);
      cfg_wr = 1'b0; wake_irq = 1'b0;
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
      tick_count++;
   endtask

   task automatic pulse_bus();
      @(negedge clk);
      bus_done = 1'b1;
      @(negedge clk);
      bus_done = 1'b0;
   endtask

   task automatic pulse_wake();
      @(negedge clk);
      wake_irq = 1'b1;
      @(negedge clk);
      wake_irq = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycle_count++;
      if (cycle_count > 100000 && !done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected below %0d", cycle_count, 100000);
         finish_run();
      end
   end

   initial begin
      int on_cnt;
      idle(3);
      // R1: reset state
      chk("R1 reset word", cfg_rdata, 16'h001F);
      chk("R1 reset enable out", {15'd0, cpu_clk_en}, 16'h0001);
      rst_n = 1'b1;
      idle(2);

      // R2: reserved bits and bit 5 read zero
      write_cfg(16'hFFBF, 1'b0);
      chk("R2 readback layout", cfg_rdata, 16'h009F);

      // R4: duty table walk
      for (int v = 0; v < NVEC; v++) begin
         write_cfg(16'h0080 | 16'(VEC_W[v]), 1'b0);
         on_cnt = 0;
         for (int s = 0; s < 31; s++) begin
            pulse_tick();
            idle(2);
            if (cpu_clk_en) on_cnt++;
         end
         chk($sformatf("R4 duty width %0d", VEC_W[v]), 16'(on_cnt), 16'(VEC_ON[v]));
      end

      // R3: disabled with on-time 0 keeps the clock running
      write_cfg(16'h0000, 1'b0);
      on_cnt = 0;
      for (int s = 0; s < 31; s++) begin
         pulse_tick();
         idle(2);
         if (cpu_clk_en) on_cnt++;
      end
      chk("R3 disabled width 0", 16'(on_cnt), 16'd31);

      // R5: wake from on-time 0 power-save
      write_cfg(16'h0080, 1'b0);
      idle(2);
      chk("R5 gated before wake", {15'd0, cpu_clk_en}, 16'h0000);
      pulse_wake();
      idle(1);
      chk("R5 enable cleared", cfg_rdata, 16'h0000);
      chk("R5 clock back", {15'd0, cpu_clk_en}, 16'h0001);

      // R5: wake wins over a simultaneous write
      write_cfg(16'h0085, 1'b1);
      idle(1);
      chk("R5 wake beats write", cfg_rdata, 16'h0005);

      // R6/R7: stop sequence with clock otherwise running
      write_cfg(16'h005F, 1'b0);
      idle(2);
      chk("R6 stop reads set", cfg_rdata, 16'h005F);
      write_cfg(16'h001F, 1'b0);
      chk("R6 write 0 keeps stop", cfg_rdata, 16'h005F);
      pulse_bus();
      idle(2);
      chk("R7 bus before tick ignored", {15'd0, cpu_clk_en}, 16'h0001);
      pulse_tick();
      idle(2);
      chk("R7 waits for bus cycle", {15'd0, cpu_clk_en}, 16'h0001);
      pulse_bus();
      chk("R10 one cycle latency", {15'd0, cpu_clk_en}, 16'h0001);
      idle(1);
      chk("R7 clock removed", {15'd0, cpu_clk_en}, 16'h0000);

      // R9: wake ends the halt
      pulse_wake();
      idle(1);
      chk("R9 clock resumed", {15'd0, cpu_clk_en}, 16'h0001);
      chk("R9 stop and enable clear", cfg_rdata, 16'h001F);

      // R8: halt ends on the wrapping tick
      write_cfg(16'h005F, 1'b0);
      pulse_tick();
      pulse_bus();
      idle(2);
      chk("R8 halted", {15'd0, cpu_clk_en}, 16'h0000);
      while ((tick_count % 31) != 30) begin
         pulse_tick();
         idle(2);
         chk("R8 stays halted", {15'd0, cpu_clk_en}, 16'h0000);
      end
      pulse_tick();
      idle(1);
      chk("R8 resumed at wrap", {15'd0, cpu_clk_en}, 16'h0001);
      chk("R8 stop cleared", cfg_rdata, 16'h001F);

      finish_run();
   end

endmodule